// File: doc/BRIEF.md
# Disk Channel Interrupt Status Unit

This block gathers the interrupt sources of a single disk channel and presents them to software through a small word-addressed register port. Two event inputs, a transfer-complete pulse from the DMA engine and a bus-error pulse, set sticky pending bits. A per-source enable mask decides which pending bits drive the level interrupt output. Software can set and clear the mask through two separate write-one registers. It retires pending bits by writing ones to the status word. The address that came with the first bus error is latched and held for software to read.

The unit also relays the attached drive's status byte through the same port. A read of that location has a side effect. When the returned byte shows the drive idle with one of the watched bits set, every pending bit is retired on the same clock edge. A driver that polls drive status therefore acknowledges the channel interrupt without a separate write. Read data is registered and appears on the cycle after the read strobe.

Top module: `disk_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, pending bits, enable mask and latched error address are all zero, `irq_o` is low and `reg_rdata_o` is zero.
- R2: A `xfer_done_i` pulse sets pending bit 0 and a `bus_err_i` pulse sets pending bit 1. A read of byte offset 0x00C returns the pending bits in bits 1:0 and zeros above them.
- R3: Writing to offset 0x014 sets each enable bit whose data bit is 1. Writing to offset 0x01C clears each enable bit whose data bit is 1. Zero data bits leave the mask unchanged. A read of 0x014 or 0x01C returns the mask in bits 1:0.
- R4: `irq_o` is high exactly when some pending bit has its enable bit set. It follows the clock edge that changes either one.
- R5: Writing to offset 0x00C clears each pending bit whose data bit is 1. Zero data bits leave their pending bits set.
- R6: When a source event and a clear of the same bit happen in one cycle, the bit ends up set.
- R7: A read of offset 0x11C returns `drv_status_i`, zero-extended, on the following cycle.
- R8: If the drive status read under R7 has any bit of mask 0x51 set, both pending bits clear on that edge. Otherwise they are unchanged. Writes to 0x11C clear nothing.
- R9: A source event in the same cycle as the read-triggered clear of R8 leaves its bit set.
- R10: The bus-error address is captured only when a bus error arrives while pending bit 1 is clear. It is held until that bit has been cleared. Its low word reads at offset 0x000 and its high word at 0x004.
- R11: Reads of unmapped offsets return zero. Writes to 0x000, 0x004 and unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| reg_addr_i | input | 12 | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_rdata_o | output | 32 | Read data, valid the cycle after `reg_rd_i` |
| xfer_done_i | input | 1 | Transfer-complete event pulse |
| bus_err_i | input | 1 | Bus-error event pulse |
| bus_err_addr_i | input | 64 | Address accompanying `bus_err_i` |
| drv_status_i | input | 8 | Current drive status byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that the event inputs are clean synchronous pulses. The auto-clear property further assumes that the drive status byte is stable during the cycle in which its read strobe is high. The stimulus drives every strobe and event for exactly one cycle, changes inputs only on the falling edge, and never combines a read with a write. Coincidences are created on purpose only between an event and a clear, which is the case the priority rule covers.

// File: rtl/disk_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets, source indices and decode types for the disk
// channel interrupt unit. Offsets are byte addresses; all registers are
// 32-bit words on 4-byte boundaries.
package disk_irq_pkg;

    localparam int unsigned OFF_STATUS  = 'h00C;  // pending bits, write-one clears
    localparam int unsigned OFF_EN_SET  = 'h014;  // write-one sets enable bits
    localparam int unsigned OFF_EN_CLR  = 'h01C;  // write-one clears enable bits
    localparam int unsigned OFF_DRV     = 'h11C;  // drive status relay, read side effect
    localparam int unsigned WORD_BYTES  = 4;      // error address word stride from offset 0

    localparam int unsigned SRC_XFER    = 0;
    localparam int unsigned SRC_BUSERR  = 1;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_ERR,
        RSEL_STATUS,
        RSEL_ENABLE,
        RSEL_DRV
    } rsel_e;

    typedef struct packed {
        logic stat_clr;   // write to pending status word
        logic en_set;     // write to enable-set word
        logic en_clr;     // write to enable-clear word
        logic drv_rd;     // read of the drive status relay
    } strobe_t;

endpackage

// File: rtl/disk_irq_regdec.sv
`timescale 1ns/1ps
// Module: disk_irq_regdec
// Purely combinational address decoder. Turns one register access into
// write/read strobes and a read-source select. Assumes read and write
// strobes are never high together and that addresses compare exactly
// over ADDR_W bits.
module disk_irq_regdec
    import disk_irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned ERR_WORDS = 2,
    localparam int unsigned IDX_W    = (ERR_WORDS > 1) ? $clog2(ERR_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output strobe_t           strb_o,
    output rsel_e             rsel_o,
    output logic [IDX_W-1:0]  err_idx_o
);

    // Write and side-effect strobes from exact address matches.
    always_comb begin
        strb_o.stat_clr = wr_i && (addr_i == ADDR_W'(OFF_STATUS));
        strb_o.en_set   = wr_i && (addr_i == ADDR_W'(OFF_EN_SET));
        strb_o.en_clr   = wr_i && (addr_i == ADDR_W'(OFF_EN_CLR));
        strb_o.drv_rd   = rd_i && (addr_i == ADDR_W'(OFF_DRV));
    end

    // Read-source select; error address words occupy the lowest offsets.
    always_comb begin
        rsel_o    = RSEL_NONE;
        err_idx_o = '0;
        for (int k = 0; k < ERR_WORDS; k++) begin
            if (addr_i == ADDR_W'(k * WORD_BYTES)) begin
                rsel_o    = RSEL_ERR;
                err_idx_o = IDX_W'(k);
            end
        end
        if (addr_i == ADDR_W'(OFF_STATUS)) rsel_o = RSEL_STATUS;
        if (addr_i == ADDR_W'(OFF_EN_SET)) rsel_o = RSEL_ENABLE;
        if (addr_i == ADDR_W'(OFF_EN_CLR)) rsel_o = RSEL_ENABLE;
        if (addr_i == ADDR_W'(OFF_DRV))    rsel_o = RSEL_DRV;
    end

endmodule

// File: rtl/disk_irq_status.sv
`timescale 1ns/1ps
// Module: disk_irq_status
// Sticky pending bits, per-source enable mask and the level interrupt.
// Each source event sets its bit; a write-one clear or a drive status read
// showing an idle drive with a watched bit set retires it. An event in the
// same cycle as any clear wins. Assumes events are one-cycle pulses.
module disk_irq_status #(
    parameter int unsigned    NUM_SRC    = 2,
    parameter int unsigned    DRV_W      = 8,
    parameter logic [DRV_W-1:0] IDLE_MASK = 8'h51
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] wbits_i,
    input  logic               stat_clr_i,
    input  logic               en_set_i,
    input  logic               en_clr_i,
    input  logic               drv_rd_i,
    input  logic [DRV_W-1:0]   drv_status_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enab_o,
    output logic               irq_o
);

    logic auto_clr;

    // Read-triggered clear: drive reports idle with a watched bit set.
    always_comb auto_clr = drv_rd_i && (|(drv_status_i & IDLE_MASK));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic clr_bit;

        // Any clear request aimed at this source in this cycle.
        always_comb clr_bit = (stat_clr_i && wbits_i[i]) || auto_clr;

        // Pending flop: event has priority over clear.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)        pend_o[i] <= 1'b0;
            else if (evt_i[i])   pend_o[i] <= 1'b1;
            else if (clr_bit)    pend_o[i] <= 1'b0;
        end

        // Enable flop: separate write-one set and write-one clear words.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)                      enab_o[i] <= 1'b0;
            else if (en_set_i && wbits_i[i])   enab_o[i] <= 1'b1;
            else if (en_clr_i && wbits_i[i])   enab_o[i] <= 1'b0;
        end
    end

    // Level interrupt from enabled pending sources.
    always_comb irq_o = |(pend_o & enab_o);

endmodule

// File: rtl/disk_irq_erraddr.sv
`timescale 1ns/1ps
// Module: disk_irq_erraddr
// Holds the address of the first bus error. Capture is allowed only while
// the error pending bit is clear, so later errors cannot overwrite it until
// software has retired the first one.
module disk_irq_erraddr #(
    parameter int unsigned ERR_ADDR_W = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  err_evt_i,
    input  logic                  err_pend_i,
    input  logic [ERR_ADDR_W-1:0] err_addr_i,
    output logic [ERR_ADDR_W-1:0] err_addr_o
);

    // Capture register, gated by the current error pending bit.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                      err_addr_o <= '0;
        else if (err_evt_i && !err_pend_i) err_addr_o <= err_addr_i;
    end

endmodule

// File: rtl/disk_irq_rdmux.sv
`timescale 1ns/1ps
// Module: disk_irq_rdmux
// Registered read-data path. On a read strobe, the selected source is
// loaded into the output register; between reads the last value is held.
// Unmapped offsets read as zero.
module disk_irq_rdmux
    import disk_irq_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ERR_ADDR_W = 64,
    parameter int unsigned NUM_SRC    = 2,
    parameter int unsigned DRV_W      = 8,
    localparam int unsigned ERR_WORDS = ERR_ADDR_W / DATA_W,
    localparam int unsigned IDX_W     = (ERR_WORDS > 1) ? $clog2(ERR_WORDS) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  rd_i,
    input  rsel_e                 rsel_i,
    input  logic [IDX_W-1:0]      err_idx_i,
    input  logic [ERR_ADDR_W-1:0] err_addr_i,
    input  logic [NUM_SRC-1:0]    pend_i,
    input  logic [NUM_SRC-1:0]    enab_i,
    input  logic [DRV_W-1:0]      drv_status_i,
    output logic [DATA_W-1:0]     rdata_o
);

    logic [DATA_W-1:0] err_words [ERR_WORDS];
    logic [DATA_W-1:0] rd_next;

    // Slice the error address into readable words.
    for (genvar w = 0; w < ERR_WORDS; w++) begin : g_errw
        always_comb err_words[w] = err_addr_i[w*DATA_W +: DATA_W];
    end

    // Source selection for the next read value.
    always_comb begin
        rd_next = '0;
        case (rsel_i)
            RSEL_ERR:    rd_next = err_words[err_idx_i];
            RSEL_STATUS: rd_next = DATA_W'(pend_i);
            RSEL_ENABLE: rd_next = DATA_W'(enab_i);
            RSEL_DRV:    rd_next = DATA_W'(drv_status_i);
            default:     rd_next = '0;
        endcase
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)  rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_next;
    end

endmodule

// File: rtl/disk_irq_unit.sv
`timescale 1ns/1ps
// Module: disk_irq_unit (top)
// Interrupt status unit for one disk channel: transfer-complete and
// bus-error sources, enable mask, level interrupt, latched error address
// and the drive status relay whose read retires pending interrupts.
// Assumes one-cycle strobes and never a read and a write together.
module disk_irq_unit
    import disk_irq_pkg::*;
#(
    parameter int unsigned      ADDR_W     = 12,
    parameter int unsigned      DATA_W     = 32,
    parameter int unsigned      ERR_ADDR_W = 64,
    parameter int unsigned      DRV_W      = 8,
    parameter logic [DRV_W-1:0] IDLE_MASK  = 8'h51
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    input  logic                  reg_rd_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  xfer_done_i,
    input  logic                  bus_err_i,
    input  logic [ERR_ADDR_W-1:0] bus_err_addr_i,
    input  logic [DRV_W-1:0]      drv_status_i,
    output logic                  irq_o
);

    localparam int unsigned NUM_SRC   = 2;
    localparam int unsigned ERR_WORDS = ERR_ADDR_W / DATA_W;
    localparam int unsigned IDX_W     = (ERR_WORDS > 1) ? $clog2(ERR_WORDS) : 1;

    strobe_t              strb;
    rsel_e                rsel;
    logic [IDX_W-1:0]     err_idx;
    logic [NUM_SRC-1:0]   evt;
    logic [NUM_SRC-1:0]   pend_q;
    logic [NUM_SRC-1:0]   enab_q;
    logic [ERR_ADDR_W-1:0] err_addr_q;

    // Gather the source events in status bit order.
    always_comb begin
        evt             = '0;
        evt[SRC_XFER]   = xfer_done_i;
        evt[SRC_BUSERR] = bus_err_i;
    end

    disk_irq_regdec #(
        .ADDR_W    (ADDR_W),
        .ERR_WORDS (ERR_WORDS)
    ) u_dec (
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .strb_o    (strb),
        .rsel_o    (rsel),
        .err_idx_o (err_idx)
    );

    disk_irq_status #(
        .NUM_SRC   (NUM_SRC),
        .DRV_W     (DRV_W),
        .IDLE_MASK (IDLE_MASK)
    ) u_stat (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .evt_i        (evt),
        .wbits_i      (reg_wdata_i[NUM_SRC-1:0]),
        .stat_clr_i   (strb.stat_clr),
        .en_set_i     (strb.en_set),
        .en_clr_i     (strb.en_clr),
        .drv_rd_i     (strb.drv_rd),
        .drv_status_i (drv_status_i),
        .pend_o       (pend_q),
        .enab_o       (enab_q),
        .irq_o        (irq_o)
    );

    disk_irq_erraddr #(
        .ERR_ADDR_W (ERR_ADDR_W)
    ) u_err (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .err_evt_i  (bus_err_i),
        .err_pend_i (pend_q[SRC_BUSERR]),
        .err_addr_i (bus_err_addr_i),
        .err_addr_o (err_addr_q)
    );

    disk_irq_rdmux #(
        .DATA_W     (DATA_W),
        .ERR_ADDR_W (ERR_ADDR_W),
        .NUM_SRC    (NUM_SRC),
        .DRV_W      (DRV_W)
    ) u_rd (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .rd_i         (reg_rd_i),
        .rsel_i       (rsel),
        .err_idx_i    (err_idx),
        .err_addr_i   (err_addr_q),
        .pend_i       (pend_q),
        .enab_i       (enab_q),
        .drv_status_i (drv_status_i),
        .rdata_o      (reg_rdata_o)
    );

endmodule

// File: rtl/disk_irq_checker.sv
`timescale 1ns/1ps
// Module: disk_irq_checker
// Temporal properties for disk_irq_unit, attached by bind. Observes the
// ports plus the pending, enable and error address state.
module disk_irq_checker
    import disk_irq_pkg::*;
#(
    parameter int unsigned      ADDR_W     = 12,
    parameter int unsigned      DATA_W     = 32,
    parameter int unsigned      ERR_ADDR_W = 64,
    parameter int unsigned      DRV_W      = 8,
    parameter logic [DRV_W-1:0] IDLE_MASK  = 8'h51
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic                  reg_rd,
    input logic                  xfer_done,
    input logic                  bus_err,
    input logic [DRV_W-1:0]      drv_status,
    input logic [1:0]            pend_q,
    input logic [1:0]            enab_q,
    input logic [ERR_ADDR_W-1:0] err_addr_q,
    input logic                  irq
);

    p_xfer_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> pend_q[0]);

    p_err_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> pend_q[1]);

    p_no_enable_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_q == 2'b00) |-> !irq);

    p_irq_follows_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && enab_q[0] && !(reg_wr && reg_addr == ADDR_W'(OFF_EN_CLR) && reg_wdata[0]))
        |=> irq);

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_STATUS) && reg_wdata[0] && !xfer_done)
        |=> !pend_q[0]);

    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_STATUS) && reg_wdata[0] && xfer_done)
        |=> pend_q[0]);

    p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFF_DRV) && (|(drv_status & IDLE_MASK))
         && !xfer_done && !bus_err)
        |=> (pend_q == 2'b00));

    p_err_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q[1]) && pend_q[1]) |-> $stable(err_addr_q));

endmodule

bind disk_irq_unit disk_irq_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ERR_ADDR_W (ERR_ADDR_W),
    .DRV_W      (DRV_W),
    .IDLE_MASK  (IDLE_MASK)
) u_chk (
    .clk        (clk_i),
    .rst_n      (rst_n_i),
    .reg_addr   (reg_addr_i),
    .reg_wr     (reg_wr_i),
    .reg_wdata  (reg_wdata_i),
    .reg_rd     (reg_rd_i),
    .xfer_done  (xfer_done_i),
    .bus_err    (bus_err_i),
    .drv_status (drv_status_i),
    .pend_q     (pend_q),
    .enab_q     (enab_q),
    .err_addr_q (err_addr_q),
    .irq        (irq_o)
);

// File: tb/sim_disk_irq_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor pops them
// when read data becomes valid; irq checks are made directly.
module sim_disk_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        xfer = 1'b0;
    logic        berr = 1'b0;
    logic [63:0] eaddr = '0;
    logic [7:0]  drv = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_prev = 1'b0;

    localparam logic [63:0] EA_A = 64'h0000_00AB_1234_5678;
    localparam logic [63:0] EA_B = 64'h0000_0011_2233_4455;
    localparam logic [63:0] EA_C = 64'h0000_0077_CAFE_F00D;

    always #2 clk = ~clk;

    disk_irq_unit u0 (
        .clk_i          (clk),
        .rst_n_i        (rst_n),
        .reg_addr_i     (addr),
        .reg_wr_i       (wr),
        .reg_wdata_i    (wdata),
        .reg_rd_i       (rd),
        .reg_rdata_o    (rdata),
        .xfer_done_i    (xfer),
        .bus_err_i      (berr),
        .bus_err_addr_i (eaddr),
        .drv_status_i   (drv),
        .irq_o          (irq)
    );

    // Monitor: read data is valid at the falling edge after the sampling edge.
    always @(posedge clk) rd_prev <= rd;
    always @(negedge clk) begin
        if (rd_prev) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        report();
    end

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk); addr = a; rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic pulse(input logic x, input logic b, input logic [63:0] ea);
        @(negedge clk); xfer = x; berr = b; eaddr = ea;
        @(negedge clk); xfer = 1'b0; berr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        n_checks++;
        if (rdata !== 32'h0) begin n_fail++; $display("FAIL R1: rdata=%h expected 0", rdata); end
        rd_reg(12'h00C, 32'h0, "R1 status zero");
        rd_reg(12'h014, 32'h0, "R1 enable zero");
        rd_reg(12'h000, 32'h0, "R1 err addr low zero");

        // R3 enable set/clear words
        wr_reg(12'h014, 32'h3);
        rd_reg(12'h014, 32'h3, "R3 enable after set");
        wr_reg(12'h01C, 32'h1);
        rd_reg(12'h01C, 32'h2, "R3 enable after clear bit0");
        wr_reg(12'h014, 32'h0);
        rd_reg(12'h014, 32'h2, "R3 zero bits no effect");
        wr_reg(12'h014, 32'h1);

        // R2/R4 transfer event
        pulse(1'b1, 1'b0, '0);
        chk_irq(1'b1, "R4 irq on enabled event");
        rd_reg(12'h00C, 32'h1, "R2 status bit0");

        // R5 write-one clear, zero bits ignored
        wr_reg(12'h00C, 32'h2);
        rd_reg(12'h00C, 32'h1, "R5 zero bit keeps pending");
        wr_reg(12'h00C, 32'h1);
        chk_irq(1'b0, "R5 irq after clear");
        rd_reg(12'h00C, 32'h0, "R5 status cleared");

        // R4 masking
        wr_reg(12'h01C, 32'h1);
        pulse(1'b1, 1'b0, '0);
        chk_irq(1'b0, "R4 masked source");
        wr_reg(12'h014, 32'h1);
        chk_irq(1'b1, "R4 unmask pending source");
        wr_reg(12'h00C, 32'h3);

        // R10 error address capture and hold
        pulse(1'b0, 1'b1, EA_A);
        chk_irq(1'b1, "R4 irq on bus error");
        rd_reg(12'h00C, 32'h2, "R2 status bit1");
        rd_reg(12'h000, EA_A[31:0], "R10 err low word");
        rd_reg(12'h004, EA_A[63:32], "R10 err high word");
        pulse(1'b0, 1'b1, EA_B);
        rd_reg(12'h000, EA_A[31:0], "R10 second error held");
        wr_reg(12'h00C, 32'h2);
        pulse(1'b0, 1'b1, EA_B);
        rd_reg(12'h000, EA_B[31:0], "R10 capture after clear");
        rd_reg(12'h004, EA_B[63:32], "R10 high after clear");

        // R11 read-only and unmapped
        wr_reg(12'h000, 32'hFFFF_FFFF);
        rd_reg(12'h000, EA_B[31:0], "R11 write to err word ignored");
        rd_reg(12'h040, 32'h0, "R11 unmapped reads zero");
        drv = 8'h50;
        wr_reg(12'h11C, 32'h3);
        rd_reg(12'h00C, 32'h2, "R8 write to relay clears nothing");
        wr_reg(12'h00C, 32'h2);

        // R6 event and clear together
        pulse(1'b1, 1'b0, '0);
        @(negedge clk); addr = 12'h00C; wdata = 32'h1; wr = 1'b1; xfer = 1'b1;
        @(negedge clk); wr = 1'b0; xfer = 1'b0;
        rd_reg(12'h00C, 32'h1, "R6 event wins over clear");

        // R7/R8 drive status relay
        pulse(1'b0, 1'b1, EA_A);
        drv = 8'h80;
        rd_reg(12'h11C, 32'h80, "R7 busy status relayed");
        rd_reg(12'h00C, 32'h3, "R8 busy read keeps pending");
        drv = 8'h50;
        rd_reg(12'h11C, 32'h50, "R7 idle status relayed");
        chk_irq(1'b0, "R8 irq after auto clear");
        rd_reg(12'h00C, 32'h0, "R8 auto clear");

        // R9 auto clear with coincident bus error
        pulse(1'b1, 1'b0, '0);
        drv = 8'h40;
        @(negedge clk); addr = 12'h11C; rd = 1'b1; berr = 1'b1; eaddr = EA_C;
        exp_q.push_back(32'h40); tag_q.push_back("R7 relay during event");
        @(negedge clk); rd = 1'b0; berr = 1'b0;
        rd_reg(12'h00C, 32'h2, "R9 event survives auto clear");
        rd_reg(12'h000, EA_C[31:0], "R10 capture at coincidence");
        chk_irq(1'b1, "R9 irq from surviving bit");

        repeat (3) @(negedge clk);
        report();
    end

endmodule